// File: doc/BRIEF.md
# Flow-through burst SRAM cycle controller

This block sits in front of a small 36-bit synchronous memory and decodes each rising clock edge into one of a few cycle kinds. A cycle can deselect the device, begin a burst at an external address, continue the burst at the next address, or hold the current address. Each cycle that touches the array is either a read or a write. Two address strobes start cycles. The processor-side strobe always begins a read, and the controller-side strobe begins a read or a write. Three chip enables, a global write, a byte-write enable and four lane write enables qualify the strobes. An advance input steps a two-bit burst counter through either a linear or an interleaved order.

Read data is not registered on the output side. The cycle address is captured at the edge, and the array word flows straight to the output. An output enable gates the driver-enable output without waiting for a clock. After a write cycle the output stays undriven. A sleep input, once held for a set number of edges, freezes the interface. The block keeps the array contents through sleep and resumes after the same number of edges with sleep released.

Top module: `fsram_ctrl`

## Requirements
- R1: The device is selected only when `ce_n`=0, `ce2`=1 and `ce3_n`=0. A strobe taken at an edge where the device is not selected is a deselect cycle. After a deselect cycle `dq_oe` is 0 and the burst ends, so later edges without a strobe do nothing.
- R2: While `ce_n`=1, a low `ads_proc_n` is ignored. If `ads_ctrl_n` is also high, that edge behaves as a strobe-free edge. If `ads_ctrl_n` is low with `ce_n`=1, the edge is a deselect cycle.
- R3: `ads_proc_n`=0 with the device selected begins a read at `addr`, whatever the write inputs show. No lane is written at that edge.
- R4: `ads_ctrl_n`=0 with `ads_proc_n`=1 and the device selected begins a burst at `addr`. It is a write if the write decode (R5) asks for one, and a read otherwise.
- R5: Lane n (n=0..3) is data bits [9n+8:9n]. `gw_n`=0 writes all four lanes. With `gw_n`=1 and `bwe_n`=0, exactly the lanes with `bw_n[n]`=0 are written. All other combinations, including `bwe_n`=0 with `bw_n`=4'b1111, decode as a read.
- R6: On an edge with both strobes high during an active burst, `adv_n`=0 moves to the next burst address and `adv_n`=1 keeps the current address. Either kind of edge is a read or a write per R5.
- R7: The low two address bits of burst step k (k=0..3, wrapping) are (start+k) mod 4 when `burst_ilv`=0, and start XOR k when `burst_ilv`=1. The upper address bits never change within a burst.
- R8: After a read cycle, `dq_out` equals the array word at that cycle's address from the same clock period on. `dq_oe` equals NOT `oe_n` at once, without waiting for a clock edge.
- R9: After a write cycle, `dq_oe` is 0 regardless of `oe_n`. It stays 0 until a later read cycle.
- R10: Once `sleep` has been sampled high on 4 consecutive edges, every following edge ignores strobes and writes, and `dq_oe` is 0. Normal operation resumes at the edge after `sleep` has been sampled low on 4 consecutive edges. The array contents are unchanged across sleep.
- R11: After reset, `dq_oe` is 0, no burst is active and the device is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Primary chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| ads_proc_n | input | 1 | Processor address strobe, active low, read-only begin |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low, all lanes |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Lane write enables, active low, bit n is lane n |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | AW | External word address (AW = log2 DEPTH) |
| din | input | 36 | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Low-power request, active high |
| dq_out | output | 36 | Read data, zero when not driven |
| dq_oe | output | 1 | Output driver enable |

## Verification
The hardest state to reach from the ports is a write made through a processor-strobe begin. The begin edge itself must ignore active write inputs. The write then has to land on the following strobe-free edge, with `adv_n` high, at the address just loaded. The stimulus starts a processor-strobe cycle with `gw_n` and the lane enables already low. It then holds the write inputs into a hold edge and reads the address back with a fresh begin. The sleep entry and exit windows are reached the same way: strobes carrying write data are offered on every edge of both four-edge windows, and a read afterwards shows which of them landed.

// File: rtl/fsram_pkg.sv
package fsram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [2:0] {
        CY_IDLE,
        CY_DESEL,
        CY_BEGIN,
        CY_NEXT,
        CY_HOLD
    } cyc_e;

    typedef struct packed {
        cyc_e             kind;
        logic             wr;
        logic [LANES-1:0] lane_we;
    } dec_t;

    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] k,
                                            input logic       ilv);
        return ilv ? (start ^ k) : (start + k);
    endfunction

endpackage

// File: rtl/fsram_decode.sv
module fsram_decode
    import fsram_pkg::*;
(
    input  logic             asleep,
    input  logic             active,
    input  logic             ce_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             ads_proc_n,
    input  logic             ads_ctrl_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output dec_t             dec
);

    logic             sel;
    logic [LANES-1:0] lanes_req;

    always_comb begin
        sel       = !ce_n && ce2 && !ce3_n;
        lanes_req = !gw_n ? {LANES{1'b1}} : (bwe_n ? '0 : ~bw_n);

        dec.kind    = CY_IDLE;
        dec.lane_we = '0;
        if (!asleep) begin
            if (!ads_proc_n && !ce_n) begin
                dec.kind = sel ? CY_BEGIN : CY_DESEL;
            end else if (!ads_ctrl_n) begin
                if (sel) begin
                    dec.kind    = CY_BEGIN;
                    dec.lane_we = lanes_req;
                end else begin
                    dec.kind = CY_DESEL;
                end
            end else if (active) begin
                dec.kind    = adv_n ? CY_HOLD : CY_NEXT;
                dec.lane_we = lanes_req;
            end
        end
        dec.wr = |dec.lane_we;
    end

endmodule

// File: rtl/fsram_burst.sv
module fsram_burst
    import fsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          ilv,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] addr_d,
    output logic [AW-1:0] addr_q
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [1:0]    k;
        logic [AW-1:0] cur;
    } bst_t;

    bst_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (load) begin
            b_d.base = ext_addr;
            b_d.k    = 2'd0;
            b_d.cur  = ext_addr;
        end else if (advance) begin
            b_d.k   = b_q.k + 2'd1;
            b_d.cur = {b_q.base[AW-1:2], burst_lo(b_q.base[1:0], b_q.k + 2'd1, ilv)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign addr_d = b_d.cur;
    assign addr_q = b_q.cur;

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> (addr_q == $past(addr_q))); // R6
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (addr_q[AW-1:2] == $past(addr_q[AW-1:2]))); // R7

endmodule

// File: rtl/fsram_array.sv
module fsram_array
    import fsram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[n]) begin
                store[waddr] <= wdata[n*LANE_W +: LANE_W];
            end
        end

        assign rdata[n*LANE_W +: LANE_W] = store[raddr];
    end

endmodule

// File: rtl/fsram_ctrl.sv
module fsram_ctrl
    import fsram_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int SLEEP_CYC = 4,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [3:0]        bw_n,
    input  logic              burst_ilv,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] din,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam int SCW = $clog2(SLEEP_CYC + 1);

    typedef struct packed {
        logic           active;
        logic           rd_valid;
        logic           asleep;
        logic [SCW-1:0] scnt;
    } ctl_t;

    ctl_t              st_d, st_q;
    dec_t              dec;
    logic [AW-1:0]     addr_d, addr_q;
    logic [DATA_W-1:0] rdata;

    fsram_decode i_decode (
        .asleep     (st_q.asleep),
        .active     (st_q.active),
        .ce_n       (ce_n),
        .ce2        (ce2),
        .ce3_n      (ce3_n),
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .adv_n      (adv_n),
        .gw_n       (gw_n),
        .bwe_n      (bwe_n),
        .bw_n       (bw_n),
        .dec        (dec)
    );

    fsram_burst #(.AW(AW)) i_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dec.kind == CY_BEGIN),
        .advance  (dec.kind == CY_NEXT),
        .ilv      (burst_ilv),
        .ext_addr (addr),
        .addr_d   (addr_d),
        .addr_q   (addr_q)
    );

    fsram_array #(.DEPTH(DEPTH), .AW(AW)) i_array (
        .clk     (clk),
        .lane_we (dec.lane_we),
        .waddr   (addr_d),
        .wdata   (din),
        .raddr   (addr_q),
        .rdata   (rdata)
    );

    always_comb begin
        st_d = st_q;
        unique case (dec.kind)
            CY_DESEL: begin
                st_d.active   = 1'b0;
                st_d.rd_valid = 1'b0;
            end
            CY_BEGIN: begin
                st_d.active   = 1'b1;
                st_d.rd_valid = !dec.wr;
            end
            CY_NEXT, CY_HOLD: st_d.rd_valid = !dec.wr;
            default:          st_d.rd_valid = 1'b0;
        endcase

        if (sleep != st_q.asleep) begin
            if (st_q.scnt == SCW'(SLEEP_CYC - 1)) begin
                st_d.asleep = !st_q.asleep;
                st_d.scnt   = '0;
            end else begin
                st_d.scnt = st_q.scnt + 1'b1;
            end
        end else begin
            st_d.scnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_oe  = st_q.rd_valid && !oe_n;
    assign dq_out = dq_oe ? rdata : '0;

    AST_WR_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
        dec.wr |=> !dq_oe); // R9
    AST_DESEL_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == CY_DESEL) |=> !dq_oe); // R1
    AST_PROC_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && !ce_n && !st_q.asleep) |-> (dec.lane_we == '0)); // R3
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.asleep |=> !dq_oe); // R10
    AST_CE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !ads_ctrl_n && !st_q.asleep) |-> (dec.kind == CY_DESEL)); // R2

endmodule

// File: tb/test_fsram_ctrl.sv
module test_fsram_ctrl;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 256;
    localparam int AW     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n, ce2, ce3_n, ads_proc_n, ads_ctrl_n, adv_n;
    logic        gw_n, bwe_n, burst_ilv, oe_n, sleep;
    logic [3:0]  bw_n;
    logic [AW-1:0] addr;
    logic [35:0] din;
    logic [35:0] dq_out;
    logic        dq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [35:0] ref_mem [DEPTH];
    bit          m_active, m_rdv, m_asleep;
    int          m_scnt;
    logic [AW-1:0] m_base, m_addr;
    int          m_k;
    string       tag;

    fsram_ctrl #(.DEPTH(DEPTH), .SLEEP_CYC(4)) i_fsram_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .burst_ilv(burst_ilv),
        .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [35:0] pat(input int a);
        logic [7:0] b = a[7:0];
        return {b, ~b, b ^ 8'h5A, ~b ^ 8'h33, 4'h6};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic pins_idle();
        ce_n = 0; ce2 = 1; ce3_n = 0; ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; din = '0;
    endtask

    // one clock edge: update the reference model, then compare half a period later
    task automatic step();
        bit sel;
        logic [3:0] lanes;
        int kind;
        bit wr;
        @(posedge clk);
        sel   = !ce_n && ce2 && !ce3_n;
        lanes = !gw_n ? 4'hF : (bwe_n ? 4'h0 : ~bw_n);
        kind  = 0;
        if (m_asleep) begin
            tag = "R10";
        end else if (!ads_proc_n && !ce_n) begin
            kind = sel ? 2 : 1; lanes = 4'h0;
            tag = sel ? "R3" : "R1";
        end else if (!ads_ctrl_n) begin
            kind = sel ? 2 : 1;
            tag = sel ? ((lanes != 0 && lanes != 4'hF) ? "R5" : "R4") : (ce_n ? "R2" : "R1");
        end else if (m_active) begin
            kind = adv_n ? 4 : 3;
            tag = adv_n ? "R6" : "R7";
        end else begin
            tag = "R1";
        end
        if (kind == 0 || kind == 1) lanes = 4'h0;
        wr = (lanes != 0);
        if (kind == 1) begin m_active = 0; m_rdv = 0; end
        else if (kind == 0) m_rdv = 0;
        else begin
            if (kind == 2) begin m_base = addr; m_k = 0; m_addr = addr; m_active = 1; end
            else if (kind == 3) begin
                m_k = (m_k + 1) % 4;
                m_addr[AW-1:2] = m_base[AW-1:2];
                m_addr[1:0] = burst_ilv ? (m_base[1:0] ^ 2'(m_k)) : 2'((int'(m_base[1:0]) + m_k) % 4);
            end
            for (int n = 0; n < 4; n++)
                if (lanes[n]) ref_mem[m_addr][n*9 +: 9] = din[n*9 +: 9];
            m_rdv = !wr;
            if (wr) tag = "R9";
        end
        if (sleep != m_asleep) begin
            if (m_scnt == 3) begin m_asleep = !m_asleep; m_scnt = 0; end
            else m_scnt++;
        end else m_scnt = 0;
        @(negedge clk);
        chk(dq_oe == (m_rdv && !oe_n), tag, 36'(dq_oe), 36'(m_rdv && !oe_n));
        if (m_rdv && !oe_n)
            chk(dq_out == ref_mem[m_addr], (tag == "R9") ? "R8" : tag, dq_out, ref_mem[m_addr]);
    endtask

    task automatic begin_rd(input logic [AW-1:0] a, input bit by_proc);
        pins_idle(); addr = a;
        if (by_proc) ads_proc_n = 0; else ads_ctrl_n = 0;
        step();
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        pins_idle(); burst_ilv = 0; sleep = 0; addr = '0;
        m_active = 0; m_rdv = 0; m_asleep = 0; m_scnt = 0; m_base = '0; m_addr = '0; m_k = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        chk(dq_oe == 0, "R11", 36'(dq_oe), 36'h0);
        step();   // strobe-free edge with no active burst: nothing happens
        chk(dq_oe == 0, "R11", 36'(dq_oe), 36'h0);

        // fill the array with ADSC global writes
        for (int a = 0; a < DEPTH; a++) begin
            pins_idle(); ads_ctrl_n = 0; gw_n = 0; addr = AW'(a); din = pat(a); step();
        end

        // R7 linear and interleaved bursts from an unaligned start
        for (int m = 0; m < 2; m++) begin
            burst_ilv = m[0];
            begin_rd(8'h21 + 8'(m), 1);
            for (int i = 0; i < 5; i++) begin pins_idle(); adv_n = 0; step(); end
        end

        // R3: processor begin with write inputs low is still a read, then R6 hold write
        burst_ilv = 0;
        pins_idle(); ads_proc_n = 0; gw_n = 0; addr = 8'h40; din = 36'h123456789; step();
        chk(dq_oe == 1 && dq_out == pat(8'h40), "R3", dq_out, pat(8'h40));
        pins_idle(); gw_n = 0; din = 36'hABCDE0123; step();
        chk(dq_oe == 0, "R9", 36'(dq_oe), 36'h0);
        pins_idle(); adv_n = 0; bwe_n = 0; bw_n = 4'b1101; din = 36'hFFFFFFFFF; step();
        begin_rd(8'h40, 1);
        chk(dq_out == 36'hABCDE0123, "R6", dq_out, 36'hABCDE0123);

        // R5 lane writes through the controller strobe
        pins_idle(); ads_ctrl_n = 0; bwe_n = 0; bw_n = 4'b1010; addr = 8'h50; din = 36'h0; step();
        begin_rd(8'h50, 0);
        chk(dq_out == (pat(8'h50) & ~{9'h0, 9'h1FF, 9'h0, 9'h1FF}), "R5", dq_out,
            pat(8'h50) & ~{9'h0, 9'h1FF, 9'h0, 9'h1FF});
        pins_idle(); ads_ctrl_n = 0; bwe_n = 0; bw_n = 4'hF; addr = 8'h51; din = 36'h0; step();
        chk(dq_oe == 1 && dq_out == pat(8'h51), "R5", dq_out, pat(8'h51));

        // R8 asynchronous output enable
        oe_n = 1; #1;
        chk(dq_oe == 0, "R8", 36'(dq_oe), 36'h0);
        oe_n = 0; #1;
        chk(dq_oe == 1, "R8", 36'(dq_oe), 36'h1);

        // R2: processor strobe ignored with ce_n high; R1 deselect by other enables
        pins_idle(); ce_n = 1; ads_proc_n = 0; addr = 8'h99; step();
        chk(dq_oe == 1 && dq_out == pat(8'h51), "R2", dq_out, pat(8'h51));
        pins_idle(); ce_n = 1; ads_ctrl_n = 0; step();
        chk(dq_oe == 0, "R2", 36'(dq_oe), 36'h0);
        begin_rd(8'h60, 0);
        pins_idle(); ce2 = 0; ads_ctrl_n = 0; step();
        chk(dq_oe == 0, "R1", 36'(dq_oe), 36'h0);
        pins_idle(); adv_n = 0; gw_n = 0; step();
        chk(dq_oe == 0, "R1", 36'(dq_oe), 36'h0);
        pins_idle(); ce3_n = 1; ads_proc_n = 0; step();
        chk(dq_oe == 0, "R1", 36'(dq_oe), 36'h0);

        // R10 sleep: write attempts in both windows and during sleep
        sleep = 1;
        for (int i = 0; i < 8; i++) begin
            pins_idle(); ads_ctrl_n = 0; gw_n = 0; addr = 8'h70 + 8'(i); din = 36'h0; step();
        end
        chk(dq_oe == 0, "R10", 36'(dq_oe), 36'h0);
        sleep = 0;
        for (int i = 0; i < 4; i++) begin
            pins_idle(); ads_ctrl_n = 0; gw_n = 0; addr = 8'h7C; din = 36'h0; step();
        end
        for (int i = 0; i < 12; i++) begin
            begin_rd(8'h70 + 8'(i), 1);
            if (i >= 4) chk(dq_out == pat(8'h70 + i), "R10", dq_out, pat(8'h70 + i));
        end

        // mixed traffic compared every edge
        for (int i = 0; i < 600; i++) begin
            pins_idle();
            burst_ilv  = ($urandom % 8) == 0 ? ~burst_ilv : burst_ilv;
            ads_proc_n = ($urandom % 5) != 0;
            ads_ctrl_n = ($urandom % 4) != 0;
            adv_n      = $urandom % 2;
            ce_n       = ($urandom % 8) == 0;
            ce2        = ($urandom % 10) != 0;
            ce3_n      = ($urandom % 10) == 0;
            gw_n       = ($urandom % 6) != 0;
            bwe_n      = $urandom % 2;
            bw_n       = 4'($urandom);
            oe_n       = ($urandom % 6) == 0;
            addr       = AW'($urandom);
            din        = {4'($urandom), 32'($urandom)};
            step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule